// File: doc/BRIEF.md
# Clock Status and Event Notification Register Block

This block is the control and status register file of an audio streaming endpoint. It is accessed through a simple request/response register bus. It holds the controller ownership address, the most recent event word, the clock source and rate selection, the stream enable word and two clock status words. The first status word covers the selected source. The second covers every source: a live lock bit for each one and a sticky slip flag for each one.

Ownership is claimed with a 64-bit compare-and-swap. Whenever an event occurs, the event word is overwritten with the new event bits only. If an owner is registered, the block also emits a single-beat write request that carries the word to the owner's address. Slip flags never produce events. A slip flag stays set until a quadlet read of the status word that holds it; a block-read beat of that word leaves the flag unchanged. A bus-reset pulse drops ownership and stops streaming.

Top module: `clock_status_regs`

## Requirements
- R1: After `rst`, the registers hold these values: owner 0xFFFF_0000_0000_0000 (no owner), event word 0, clock select 0x0000_020C (source 0x0C = internal, rate code 0x02), enable 0, all slip flags 0, `stream_run_o` 0 and `ntf_valid_o` 0.
- R2: A compare-and-swap (op 3) at word address 0 returns the old 64-bit owner on `rsp_rdata_o`. The owner takes `req_swap_i` only when `req_cmp_i` equals its current value. Quadlet writes to owner addresses 0 and 1 have no effect. A quadlet read of address 0 returns owner bits 63:32, and a quadlet read of address 1 returns bits 31:0.
- R3: A `bus_rst_i` pulse returns the owner to the no-owner value and clears the enable word. This takes priority over a compare-and-swap or a write in the same cycle.
- R4: The event word has these bits: bit 0 receive config change (`rx_cfg_chg_i`), bit 1 transmit config change (`tx_cfg_chg_i`), bit 4 lock change of the selected source, bit 5 clock select write accepted, bit 6 lock change of any source. In a cycle with any event, the word is replaced by exactly that cycle's event bits, at the same clock edge that registers the event. The word is read at address 2.
- R5: In the same edge where the event word is replaced, and only if an owner is registered, `ntf_valid_o` pulses for one cycle. `ntf_addr_o` then carries the owner value and `ntf_data_o` carries the new word.
- R6: While the owner holds the no-owner value, no notification request is issued, but the event word is still updated.
- R7: A quadlet write (op 1) to address 3 stores bits 15:0 as the clock select (source in 7:0, rate code in 15:8) and raises event bit 5 at that edge. Streams keep running across this write.
- R8: The enable word is at address 4. `stream_run_o` equals `chan_valid_i` one cycle after the enable word becomes non-zero, and equals 0 one cycle after it becomes zero.
- R9: The all-source status word at address 6 shows the registered lock inputs in bits 10:0. Any change of `lock_i` raises event bit 6.
- R10: The selected source is locked when the source code is 0x0C (internal), or when the code is below 11 and `lock_i[code]` is set. The status word at address 5 carries that lock flag in bit 0. It carries the rate code in bits 15:8: `rate_code_i` when locked, 0x0A when not. A change of the flag raises event bit 4.
- R11: Slip flags sit in bits 26:16 of address 6. A `slip_i` pulse sets its flag, the flag stays set, and no slip ever raises an event or a notification.
- R12: A quadlet read (op 0) of address 6 returns the flags and then clears them, except for a flag whose pulse arrives in that same cycle. A block-read beat (op 2) returns the same data and clears nothing.
- R13: Every read and compare-and-swap is answered with `rsp_valid_o` high exactly one cycle after the request. Writes get no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Bus request valid |
| req_op_i | input | 2 | 0 quadlet read, 1 quadlet write, 2 block-read beat, 3 compare-and-swap |
| req_addr_i | input | 4 | Quadlet word address |
| req_wdata_i | input | 32 | Quadlet write data |
| req_cmp_i | input | 64 | Compare value for compare-and-swap |
| req_swap_i | input | 64 | New value for compare-and-swap |
| rsp_valid_o | output | 1 | Read or compare-and-swap response valid |
| rsp_rdata_o | output | 64 | Read data (low 32 bits for quadlet reads) or old owner |
| bus_rst_i | input | 1 | Bus reset pulse |
| rx_cfg_chg_i | input | 1 | Receive configuration change pulse |
| tx_cfg_chg_i | input | 1 | Transmit configuration change pulse |
| lock_i | input | 11 | Per-source lock levels |
| slip_i | input | 11 | Per-source slip error pulses |
| rate_code_i | input | 8 | Measured rate code of the selected source |
| chan_valid_i | input | 4 | Per-stream valid channel flags |
| stream_run_o | output | 4 | Per-stream run indication |
| ntf_valid_o | output | 1 | Notification write request, single beat |
| ntf_addr_o | output | 64 | Notification destination (owner value) |
| ntf_data_o | output | 32 | Notification data (new event word) |

## Verification
The bench builds the block with its default parameters: 11 clock sources, 4 streams and a 4-bit word address. With 11 sources, both the top lock bit 10 and the top slip bit 26 are exercised. Random slip pulses are mixed with random quadlet reads and block-read beats. This makes same-cycle pulse-and-clear collisions occur many times. Random compare-and-swap traffic, with both matching and mismatching compare values, runs against an owner model kept in the bench.

// File: rtl/clk_stat_pkg.sv
package clk_stat_pkg;
  typedef enum logic [1:0] {
    OP_QRD = 2'd0,
    OP_QWR = 2'd1,
    OP_BRD = 2'd2,
    OP_CAS = 2'd3
  } bus_op_e;

  localparam int WA_OWN_HI = 0;
  localparam int WA_OWN_LO = 1;
  localparam int WA_EVENT  = 2;
  localparam int WA_CLKSEL = 3;
  localparam int WA_ENABLE = 4;
  localparam int WA_STATUS = 5;
  localparam int WA_EXTSTS = 6;

  localparam int EVB_RX  = 0;
  localparam int EVB_TX  = 1;
  localparam int EVB_CUR = 4;
  localparam int EVB_ACC = 5;
  localparam int EVB_ANY = 6;

  localparam logic [63:0] OWNER_NONE   = 64'hFFFF_0000_0000_0000;
  localparam logic [7:0]  SRC_INTERNAL = 8'h0C;
  localparam logic [7:0]  RATE_NONE    = 8'h0A;
  localparam logic [15:0] CLKSEL_INIT  = 16'h020C;
endpackage

// File: rtl/owner_cas.sv
module owner_cas #(
  parameter int OWN_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_rst_i,
  input  logic             cas_go_i,
  input  logic [OWN_W-1:0] cmp_i,
  input  logic [OWN_W-1:0] swap_i,
  output logic [OWN_W-1:0] owner_o,
  output logic             owner_set_o
);
  import clk_stat_pkg::*;

  localparam logic [OWN_W-1:0] NONE_VAL = OWN_W'(OWNER_NONE);

  logic [OWN_W-1:0] owner_q;
  logic             hit;

  assign hit = cas_go_i && (cmp_i == owner_q);

  always_ff @(posedge clk) begin
    if (rst || bus_rst_i) owner_q <= NONE_VAL;
    else if (hit)         owner_q <= swap_i;
  end

  assign owner_o     = owner_q;
  assign owner_set_o = (owner_q != NONE_VAL);

  assert_owner_guard_R2: assert property (@(posedge clk) disable iff (rst)
    !($past(cas_go_i) || $past(bus_rst_i)) |-> $stable(owner_q));

  assert_owner_busrst_R3: assert property (@(posedge clk) disable iff (rst)
    bus_rst_i |=> (owner_q == NONE_VAL));
endmodule

// File: rtl/lock_slip_track.sv
module lock_slip_track #(
  parameter int NSRC  = 11,
  parameter int SEL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSRC-1:0]  lock_i,
  input  logic [NSRC-1:0]  slip_i,
  input  logic             clr_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [NSRC-1:0]  lock_o,
  output logic [NSRC-1:0]  slip_o,
  output logic             any_chg_o,
  output logic             cur_lock_o,
  output logic             cur_chg_o
);
  import clk_stat_pkg::*;

  logic [NSRC-1:0] lock_q;
  logic [NSRC-1:0] slip_q;
  logic            cur_q;
  logic            cur_d;

  always_comb begin
    cur_d = (sel_i == SEL_W'(SRC_INTERNAL));
    for (int i = 0; i < NSRC; i++) begin
      if (sel_i == SEL_W'(i)) cur_d = lock_i[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q <= '0;
      cur_q  <= 1'b1;
    end else begin
      lock_q <= lock_i;
      cur_q  <= cur_d;
    end
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_slip
    always_ff @(posedge clk) begin
      if (rst)            slip_q[g] <= 1'b0;
      else if (slip_i[g]) slip_q[g] <= 1'b1;
      else if (clr_i)     slip_q[g] <= 1'b0;
    end
  end

  assign any_chg_o  = (lock_i != lock_q);
  assign cur_chg_o  = (cur_d != cur_q);
  assign lock_o     = lock_q;
  assign slip_o     = slip_q;
  assign cur_lock_o = cur_q;

  assert_slip_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    !$past(clr_i) |-> (($past(slip_q) & ~slip_q) == '0));

  assert_slip_keep_pulse_R12: assert property (@(posedge clk) disable iff (rst)
    $past(clr_i) |-> (($past(slip_i) & ~slip_q) == '0));
endmodule

// File: rtl/event_notify.sv
module event_notify #(
  parameter int WORD_W = 32,
  parameter int OWN_W  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] ev_i,
  input  logic [OWN_W-1:0]  owner_i,
  input  logic              owner_set_i,
  output logic [WORD_W-1:0] word_o,
  output logic              ntf_valid_o,
  output logic [OWN_W-1:0]  ntf_addr_o,
  output logic [WORD_W-1:0] ntf_data_o
);
  import clk_stat_pkg::*;

  logic [WORD_W-1:0] word_q;
  logic [WORD_W-1:0] data_q;
  logic [OWN_W-1:0]  addr_q;
  logic              v_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      data_q <= '0;
      addr_q <= '0;
      v_q    <= 1'b0;
    end else begin
      v_q <= 1'b0;
      if (|ev_i) begin
        word_q <= ev_i;
        data_q <= ev_i;
        addr_q <= owner_i;
        v_q    <= owner_set_i;
      end
    end
  end

  assign word_o      = word_q;
  assign ntf_valid_o = v_q;
  assign ntf_addr_o  = addr_q;
  assign ntf_data_o  = data_q;

  assert_ntf_owner_R6: assert property (@(posedge clk) disable iff (rst)
    ntf_valid_o |-> (ntf_addr_o != OWN_W'(OWNER_NONE)));

  assert_ntf_nonzero_R5: assert property (@(posedge clk) disable iff (rst)
    ntf_valid_o |-> (ntf_data_o != '0));
endmodule

// File: rtl/clock_status_regs.sv
module clock_status_regs #(
  parameter int NSRC     = 11,
  parameter int NSTRM    = 4,
  parameter int ADDR_W   = 4,
  parameter int SLIP_LSB = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid_i,
  input  logic [1:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [31:0]       req_wdata_i,
  input  logic [63:0]       req_cmp_i,
  input  logic [63:0]       req_swap_i,
  output logic              rsp_valid_o,
  output logic [63:0]       rsp_rdata_o,
  input  logic              bus_rst_i,
  input  logic              rx_cfg_chg_i,
  input  logic              tx_cfg_chg_i,
  input  logic [NSRC-1:0]   lock_i,
  input  logic [NSRC-1:0]   slip_i,
  input  logic [7:0]        rate_code_i,
  input  logic [NSTRM-1:0]  chan_valid_i,
  output logic [NSTRM-1:0]  stream_run_o,
  output logic              ntf_valid_o,
  output logic [63:0]       ntf_addr_o,
  output logic [31:0]       ntf_data_o
);
  import clk_stat_pkg::*;

  localparam int WORD_W = 32;
  localparam int OWN_W  = 64;
  localparam int SEL_W  = 16;

  localparam logic [ADDR_W-1:0] A_OWN_HI = ADDR_W'(WA_OWN_HI);
  localparam logic [ADDR_W-1:0] A_OWN_LO = ADDR_W'(WA_OWN_LO);
  localparam logic [ADDR_W-1:0] A_EVENT  = ADDR_W'(WA_EVENT);
  localparam logic [ADDR_W-1:0] A_CLKSEL = ADDR_W'(WA_CLKSEL);
  localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(WA_ENABLE);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(WA_STATUS);
  localparam logic [ADDR_W-1:0] A_EXTSTS = ADDR_W'(WA_EXTSTS);

  bus_op_e op;
  logic is_rd, is_wr, is_cas;
  logic cas_go, sel_wr, en_wr, slip_clr;

  logic [SEL_W-1:0]  sel_q;
  logic [WORD_W-1:0] en_q;
  logic [NSTRM-1:0]  run_q;
  logic              rsp_v_q;
  logic [63:0]       rsp_d_q;

  logic [OWN_W-1:0]  owner;
  logic              owner_set;
  logic [NSRC-1:0]   lock_v, slip_v;
  logic              any_chg, cur_lock, cur_chg;
  logic [WORD_W-1:0] ev_vec, ev_word;
  logic [WORD_W-1:0] sts_word, ext_word;
  logic [63:0]       rd_mux;

  assign op       = bus_op_e'(req_op_i);
  assign is_rd    = req_valid_i && (op == OP_QRD || op == OP_BRD);
  assign is_wr    = req_valid_i && (op == OP_QWR);
  assign is_cas   = req_valid_i && (op == OP_CAS);
  assign cas_go   = is_cas && (req_addr_i == A_OWN_HI);
  assign sel_wr   = is_wr && (req_addr_i == A_CLKSEL);
  assign en_wr    = is_wr && (req_addr_i == A_ENABLE);
  assign slip_clr = req_valid_i && (op == OP_QRD) && (req_addr_i == A_EXTSTS);

  owner_cas #(.OWN_W(OWN_W)) i_owner (
    .clk         (clk),
    .rst         (rst),
    .bus_rst_i   (bus_rst_i),
    .cas_go_i    (cas_go),
    .cmp_i       (req_cmp_i),
    .swap_i      (req_swap_i),
    .owner_o     (owner),
    .owner_set_o (owner_set)
  );

  lock_slip_track #(.NSRC(NSRC), .SEL_W(8)) i_lock (
    .clk        (clk),
    .rst        (rst),
    .lock_i     (lock_i),
    .slip_i     (slip_i),
    .clr_i      (slip_clr),
    .sel_i      (sel_q[7:0]),
    .lock_o     (lock_v),
    .slip_o     (slip_v),
    .any_chg_o  (any_chg),
    .cur_lock_o (cur_lock),
    .cur_chg_o  (cur_chg)
  );

  always_comb begin
    ev_vec          = '0;
    ev_vec[EVB_RX]  = rx_cfg_chg_i;
    ev_vec[EVB_TX]  = tx_cfg_chg_i;
    ev_vec[EVB_CUR] = cur_chg;
    ev_vec[EVB_ACC] = sel_wr;
    ev_vec[EVB_ANY] = any_chg;
  end

  event_notify #(.WORD_W(WORD_W), .OWN_W(OWN_W)) i_notify (
    .clk         (clk),
    .rst         (rst),
    .ev_i        (ev_vec),
    .owner_i     (owner),
    .owner_set_i (owner_set),
    .word_o      (ev_word),
    .ntf_valid_o (ntf_valid_o),
    .ntf_addr_o  (ntf_addr_o),
    .ntf_data_o  (ntf_data_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= CLKSEL_INIT;
      en_q  <= '0;
      run_q <= '0;
    end else begin
      if (sel_wr) sel_q <= req_wdata_i[SEL_W-1:0];
      if (bus_rst_i)  en_q <= '0;
      else if (en_wr) en_q <= req_wdata_i;
      run_q <= (en_q != '0) ? chan_valid_i : '0;
    end
  end

  always_comb begin
    sts_word       = '0;
    sts_word[0]    = cur_lock;
    sts_word[15:8] = cur_lock ? rate_code_i : RATE_NONE;
    ext_word                   = '0;
    ext_word[NSRC-1:0]         = lock_v;
    ext_word[SLIP_LSB +: NSRC] = slip_v;
  end

  always_comb begin
    rd_mux = '0;
    if (is_cas) begin
      rd_mux = owner;
    end else begin
      case (req_addr_i)
        A_OWN_HI: rd_mux[31:0] = owner[63:32];
        A_OWN_LO: rd_mux[31:0] = owner[31:0];
        A_EVENT:  rd_mux[31:0] = ev_word;
        A_CLKSEL: rd_mux[31:0] = {16'd0, sel_q};
        A_ENABLE: rd_mux[31:0] = en_q;
        A_STATUS: rd_mux[31:0] = sts_word;
        A_EXTSTS: rd_mux[31:0] = ext_word;
        default:  rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_v_q <= 1'b0;
      rsp_d_q <= '0;
    end else begin
      rsp_v_q <= is_rd || is_cas;
      if (is_rd || is_cas) rsp_d_q <= rd_mux;
    end
  end

  assign rsp_valid_o  = rsp_v_q;
  assign rsp_rdata_o  = rsp_d_q;
  assign stream_run_o = run_q;

  assert_rsp_latency_R13: assert property (@(posedge clk) disable iff (rst)
    rsp_valid_o |-> ($past(req_valid_i) && ($past(req_op_i) != 2'd1)));

  assert_enable_busrst_R3: assert property (@(posedge clk) disable iff (rst)
    bus_rst_i |=> (en_q == '0));

  assert_run_off_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(en_q) == '0) |-> (stream_run_o == '0));

  assert_clksel_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(sel_wr) |-> $stable(sel_q));
endmodule

// File: tb/test_clock_status_regs.sv
module test_clock_status_regs;
  localparam int NSRC = 11;
  localparam int NSTRM = 4;
  localparam logic [63:0] NONE = 64'hFFFF_0000_0000_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [1:0] req_op = 2'd0;
  logic [3:0] req_addr = 4'd0;
  logic [31:0] req_wdata = '0;
  logic [63:0] req_cmp = '0, req_swap = '0;
  logic rsp_valid;
  logic [63:0] rsp_rdata;
  logic bus_rst = 1'b0, rx_chg = 1'b0, tx_chg = 1'b0;
  logic [NSRC-1:0] lock = '0, slip = '0;
  logic [7:0] rate = 8'h02;
  logic [NSTRM-1:0] chv = 4'b1011;
  logic [NSTRM-1:0] run;
  logic ntf_v;
  logic [63:0] ntf_a;
  logic [31:0] ntf_d;

  int checks = 0, errors = 0;
  bit done = 0;
  logic s_v;
  logic [63:0] s_a;
  logic [31:0] s_d;

  always #5 clk = ~clk;

  clock_status_regs i_clock_status_regs (
    .clk(clk), .rst(rst), .req_valid_i(req_valid), .req_op_i(req_op),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_cmp_i(req_cmp),
    .req_swap_i(req_swap), .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .bus_rst_i(bus_rst), .rx_cfg_chg_i(rx_chg), .tx_cfg_chg_i(tx_chg),
    .lock_i(lock), .slip_i(slip), .rate_code_i(rate), .chan_valid_i(chv),
    .stream_run_o(run), .ntf_valid_o(ntf_v), .ntf_addr_o(ntf_a), .ntf_data_o(ntf_d)
  );

  function automatic logic [31:0] ext_exp(logic [NSRC-1:0] lk, logic [NSRC-1:0] sl);
    logic [31:0] w = '0;
    w[NSRC-1:0] = lk;
    w[16 +: NSRC] = sl;
    return w;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic snap();
    s_v = ntf_v; s_a = ntf_a; s_d = ntf_d;
  endtask

  task automatic bus(input logic [1:0] op, input logic [3:0] a, input logic [31:0] wd,
                     input logic [63:0] cmp, input logic [63:0] sw, output logic [63:0] rd,
                     output logic rv);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = wd; req_cmp = cmp; req_swap = sw;
    @(posedge clk); #1;
    snap();
    @(negedge clk);
    req_valid = 1'b0;
    rd = rsp_rdata; rv = rsp_valid;
    @(posedge clk); #1;
  endtask

  task automatic rd32(input logic [3:0] a, output logic [63:0] rd);
    logic rv;
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd0; req_addr = a;
    @(posedge clk); #1;
    rd = rsp_rdata; rv = rsp_valid;
    snap();
    @(negedge clk);
    req_valid = 1'b0;
    chk("R13 read response valid", {63'd0, rv}, 64'd1);
  endtask

  task automatic wr32(input logic [3:0] a, input logic [31:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd1; req_addr = a; req_wdata = wd;
    @(posedge clk); #1;
    snap();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic cas(input logic [63:0] cmp, input logic [63:0] sw, output logic [63:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd3; req_addr = 4'd0; req_cmp = cmp; req_swap = sw;
    @(posedge clk); #1;
    rd = rsp_rdata;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic cfg_pulse(input logic rx, input logic tx);
    @(negedge clk);
    rx_chg = rx; tx_chg = tx;
    @(posedge clk); #1;
    snap();
    @(negedge clk);
    rx_chg = 1'b0; tx_chg = 1'b0;
  endtask

  task automatic set_lock(input logic [NSRC-1:0] v);
    @(negedge clk);
    lock = v;
    @(posedge clk); #1;
    snap();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] rd, model;
    logic [NSRC-1:0] sticky;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    rd32(4'd0, rd); chk("R1 owner hi", rd, 64'h0000_0000_FFFF_0000);
    rd32(4'd1, rd); chk("R1 owner lo", rd, 64'd0);
    rd32(4'd2, rd); chk("R1 event word", rd, 64'd0);
    rd32(4'd3, rd); chk("R1 clock select", rd, 64'h020C);
    rd32(4'd4, rd); chk("R1 enable", rd, 64'd0);
    rd32(4'd6, rd); chk("R1 slip clear", rd, 64'd0);
    chk("R1 run", {60'd0, run}, 64'd0);
    chk("R1 ntf idle", {63'd0, ntf_v}, 64'd0);

    // R6 event recorded without owner, no request
    cfg_pulse(1'b1, 1'b0);
    chk("R6 no request without owner", {63'd0, s_v}, 64'd0);
    rd32(4'd2, rd); chk("R6 word recorded", rd, 64'h1);

    // R2 compare-and-swap
    cas(64'h1234, 64'h0002_0000_1000_0040, rd);
    chk("R2 cas mismatch old value", rd, NONE);
    rd32(4'd0, rd); chk("R2 mismatch keeps owner", rd, 64'hFFFF_0000);
    cas(NONE, 64'h0002_0000_1000_0040, rd);
    chk("R2 cas match old value", rd, NONE);
    wr32(4'd1, 32'hDEAD_BEEF);
    rd32(4'd1, rd); chk("R2 quadlet write ignored lo", rd, 64'h1000_0040);
    rd32(4'd0, rd); chk("R2 owner hi after swap", rd, 64'h0002_0000);

    // R4 R5 notification
    cfg_pulse(1'b0, 1'b1);
    chk("R5 ntf valid", {63'd0, s_v}, 64'd1);
    chk("R5 ntf addr", s_a, 64'h0002_0000_1000_0040);
    chk("R5 ntf data", {32'd0, s_d}, 64'h2);
    cfg_pulse(1'b1, 1'b1);
    chk("R4 combined events replace", {32'd0, s_d}, 64'h3);
    rd32(4'd2, rd); chk("R4 word read", rd, 64'h3);
    chk("R5 single beat", {63'd0, ntf_v}, 64'd0);

    // R9 any-source lock
    set_lock('1);
    chk("R9 lock change event", {31'd0, s_v, s_d}, 64'h1_0000_0040);
    rd32(4'd6, rd); chk("R9 live lock bits", rd, {32'd0, ext_exp('1, '0)});

    // R7 clock select write
    wr32(4'd3, 32'h0000_0403);
    chk("R7 accepted event", {31'd0, s_v, s_d}, 64'h1_0000_0020);
    rd32(4'd3, rd); chk("R7 select stored", rd, 64'h0403);

    // R10 selected source lock
    rate = 8'h04;
    set_lock(11'h7F7);
    chk("R10 cur and any change", {32'd0, s_d}, 64'h50);
    rd32(4'd5, rd); chk("R10 unlocked status", rd, 64'h0A00);
    set_lock('1);
    chk("R10 relock event", {32'd0, s_d}, 64'h50);
    rd32(4'd5, rd); chk("R10 locked status", rd, 64'h0401);
    wr32(4'd3, 32'h0000_020C);
    chk("R7 second accept", {32'd0, s_d}, 64'h20);

    // R8 enable
    wr32(4'd4, 32'h1);
    @(posedge clk); #1;
    chk("R8 run follows valid channels", {60'd0, run}, 64'hB);
    wr32(4'd3, 32'h0000_020C);
    @(posedge clk); #1;
    chk("R7 run kept across select write", {60'd0, run}, 64'hB);
    wr32(4'd4, 32'h0);
    @(posedge clk); #1;
    chk("R8 run stops", {60'd0, run}, 64'h0);

    // R11 R12 random slip pulses with reads
    sticky = '0;
    for (int it = 0; it < 300; it++) begin
      int k;
      logic [NSRC-1:0] p;
      k = $urandom_range(0, 3);
      p = ($urandom_range(0, 2) == 0) ? NSRC'($urandom) & NSRC'($urandom) : '0;
      if (it == 5) begin p = 11'h400; k = 1; end
      @(negedge clk);
      slip = p;
      req_valid = (k != 0); req_op = (k == 1) ? 2'd0 : 2'd2; req_addr = 4'd6;
      @(posedge clk); #1;
      chk("R11 slip raises no request", {63'd0, ntf_v}, 64'd0);
      if (k != 0)
        chk((k == 1) ? "R12 quadlet read data" : "R12 block read data",
            rsp_rdata, {32'd0, ext_exp('1, sticky)});
      sticky = ((k == 1) ? '0 : sticky) | p;
    end
    @(negedge clk); slip = '0; req_valid = 1'b0;
    begin
      logic rv;
      bus(2'd2, 4'd6, 32'd0, 64'd0, 64'd0, rd, rv);
      chk("R12 block read keeps flags", rd, {32'd0, ext_exp('1, sticky)});
      rd32(4'd6, rd); chk("R12 quadlet read value", rd, {32'd0, ext_exp('1, sticky)});
      rd32(4'd6, rd); chk("R12 flags cleared", rd, {32'd0, ext_exp('1, '0)});
      bus(2'd1, 4'd4, 32'd0, 64'd0, 64'd0, rd, rv);
      chk("R13 write no response", {63'd0, rv}, 64'd0);
    end

    // R2 random compare-and-swap
    model = 64'h0002_0000_1000_0040;
    for (int it = 0; it < 40; it++) begin
      logic [63:0] c, s;
      c = ($urandom_range(0, 1) == 0) ? model : {$urandom, $urandom};
      s = {$urandom, $urandom};
      cas(c, s, rd);
      chk("R2 random cas old", rd, model);
      if (c == model) model = s;
    end
    rd32(4'd1, rd); chk("R2 random final lo", rd, {32'd0, model[31:0]});

    // R3 bus reset
    wr32(4'd4, 32'h5);
    @(negedge clk); bus_rst = 1'b1;
    @(negedge clk); bus_rst = 1'b0;
    rd32(4'd0, rd); chk("R3 owner dropped", rd, 64'hFFFF_0000);
    rd32(4'd4, rd); chk("R3 enable cleared", rd, 64'd0);
    cfg_pulse(1'b0, 1'b1);
    chk("R6 no request after bus reset", {63'd0, s_v}, 64'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule